// File: doc/BRIEF.md
# Asynchronous SRAM-Style Streaming Buffer Port

This block is the slave end of a host-facing port that looks like an asynchronous static RAM. A host processor drives an active-low chip enable, an active-low output enable, an active-low write enable, an 8-bit address and a shared 16-bit data bus. The block gives that host access to a few small control registers and to an internal streaming buffer. All host strobes, the address and the write data are carried into the block's own clock domain through two-flop synchronizers. Edges are detected on the synchronized copies.

The upper half of the address space, with address bit 7 set, is the buffer window. Every address in that window reaches the same stream. A host whose DMA engine auto-increments its address can therefore tie one of its high-order lines to bit 7 and still hit the buffer on every access. Two advance rules are offered for reads. In the first, the read pointer moves on each rising edge of output enable. In the second, it moves on each toggle of address bit 0 while output enable stays low. A host with a fixed address can then stream words out without auto-increment.

A transfer-size register sets the number of reads that may advance the pointer. When that count is spent, a done flag is set and further advances are refused until the size is loaded again. A buffer-select register chooses which of the internal buffers is read and written.

Top module: `sram_stream_port`

## Requirements
- R1: Address bit 7 = 1 selects the buffer window, whatever the other address bits are. Address bit 7 = 0 selects the registers, decoded on address bits [1:0]: 0 = mode, 1 = buffer select, 2 = transfer size, 3 = status (read only).
- R2: A write in the buffer window stores the data word at the write pointer of the selected buffer, and the write pointer then steps by one. Words written in sequence are read back in the same sequence.
- R3: When mode bit 0 = 0, each rising edge of output enable that ends a buffer-window read (chip enable low, write enable high) advances the read pointer by one word and decrements the remaining count by one.
- R4: When mode bit 0 = 1, each toggle of address bit 0 during a buffer-window read (chip enable and output enable low) advances the read pointer by one. In each mode, the event that belongs to the other mode leaves the pointer unchanged.
- R5: Bit 0 of the buffer-select register picks which of the two buffers the buffer window reads and writes. The contents of the other buffer are kept.
- R6: Writing the transfer-size register loads the remaining count from data bits [7:0], clears the done flag, and resets the read and write pointers to word 0.
- R7: When an advance brings the remaining count to zero, the done flag is set. Later read events then leave the pointer and the count unchanged. The status register reads the remaining count in bits [15:8] and the done flag in bit 0, with all other bits zero.
- R8: The block drives the data bus only while chip enable and output enable are low and write enable is high. At all other times the bus is released.
- R9: After reset, the mode, buffer-select and transfer-size registers are zero, and the status register reads zero.
- R10: An output-enable low period of any length produces exactly one advance, at its rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostCeN | input | 1 | Host chip enable, active low, asynchronous |
| hostOeN | input | 1 | Host output enable, active low, asynchronous |
| hostWeN | input | 1 | Host write enable, active low, asynchronous |
| hostAddr | input | 8 | Host address; bit 7 selects the buffer window |
| hostData | inout | 16 | Shared data bus |

## Verification
The bench builds the block with its default parameters: two buffers of sixteen words each and an 8-bit count. These values let a single run reach both buffers, transfers that leave unwritten words beyond the count, and both advance modes. Random rounds choose the buffer, the mode and a length from 1 to 10. Each round writes one word beyond the count, so that a refused advance after done can be seen at the data bus. Directed cases hold output enable low for a long time, send the event of the wrong mode, and probe the released bus through pull-ups while write enable is low.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;

  // register offsets inside the register window (address bit 7 low)
  localparam logic [1:0] OFS_MODE   = 2'd0;
  localparam logic [1:0] OFS_SELECT = 2'd1;
  localparam logic [1:0] OFS_SIZE   = 2'd2;
  localparam logic [1:0] OFS_STATUS = 2'd3;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic              advRd;   // one read-pointer step
    logic              wrEn;    // one host write completed
    logic [ADDR_W-1:0] wrAddr;  // synchronized write address
    logic [DATA_W-1:0] wrData;  // synchronized write data
  } portStrobe_t;
endpackage

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_port_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ceN,
  input  logic               oeN,
  input  logic               weN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  dataIn,
  input  logic               modeA0,
  output portStrobe_t        stb,
  output logic [COUNT_W-1:0] remaining,
  output logic               done
);
  localparam int SYNC_W = 3 + ADDR_W + DATA_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {3'b111, {(SYNC_W-3){1'b0}}};

  logic [SYNC_W-1:0] syncA, syncB;
  logic              ceS, oeS, weS;
  logic [ADDR_W-1:0] addrS;
  logic [DATA_W-1:0] dataS;
  logic              prevOe, prevWe, prevA0;
  logic              oeRise, weRise, a0Toggle, advEvent, loadSize;

  // two-flop synchronizer over strobes, address and data together
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= SYNC_RST;
      syncB <= SYNC_RST;
    end else begin
      syncA <= {ceN, oeN, weN, addr, dataIn};
      syncB <= syncA;
    end
  end

  assign ceS   = syncB[SYNC_W-1];
  assign oeS   = syncB[SYNC_W-2];
  assign weS   = syncB[SYNC_W-3];
  assign addrS = syncB[DATA_W +: ADDR_W];
  assign dataS = syncB[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOe <= 1'b1;
      prevWe <= 1'b1;
      prevA0 <= 1'b0;
    end else begin
      prevOe <= oeS;
      prevWe <= weS;
      prevA0 <= addrS[0];
    end
  end

  assign oeRise   = oeS && !prevOe;
  assign weRise   = weS && !prevWe;
  assign a0Toggle = addrS[0] ^ prevA0;

  always_comb begin
    if (modeA0) advEvent = a0Toggle && !ceS && !oeS && weS && addrS[7];
    else        advEvent = oeRise && !ceS && weS && addrS[7];
  end

  assign stb.advRd  = advEvent && (remaining != '0);
  assign stb.wrEn   = weRise && !ceS;
  assign stb.wrAddr = addrS;
  assign stb.wrData = dataS;
  assign loadSize   = stb.wrEn && !addrS[7] && (addrS[1:0] == OFS_SIZE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
      done      <= 1'b0;
    end else if (loadSize) begin
      remaining <= dataS[COUNT_W-1:0];
      done      <= 1'b0;
    end else if (stb.advRd) begin
      remaining <= remaining - 1'b1;
      if (remaining == COUNT_W'(1)) done <= 1'b1;
    end
  end
endmodule

// File: rtl/sram_port_datapath.sv
module sram_port_datapath
  import sram_port_pkg::*;
#(
  parameter int NBUF    = 2,
  parameter int DEPTH   = 16,
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  portStrobe_t        stb,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [COUNT_W-1:0] remaining,
  input  logic               done,
  output logic               modeA0,
  output logic [DATA_W-1:0]  rdData
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int SEL_W = (NBUF > 1) ? $clog2(NBUF) : 1;
  localparam int WORDS = NBUF * DEPTH;

  logic [DATA_W-1:0]  mem [WORDS];
  logic [SEL_W-1:0]   bufSel;
  logic [PTR_W-1:0]   rdPtr, wrPtr;
  logic [COUNT_W-1:0] sizeReg;
  logic               wrBuf, wrReg;
  logic [DATA_W-1:0]  statusWord;

  assign wrBuf = stb.wrEn && stb.wrAddr[7];
  assign wrReg = stb.wrEn && !stb.wrAddr[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeA0  <= 1'b0;
      bufSel  <= '0;
      sizeReg <= '0;
      rdPtr   <= '0;
      wrPtr   <= '0;
    end else begin
      if (stb.advRd) rdPtr <= rdPtr + 1'b1;
      if (wrBuf)     wrPtr <= wrPtr + 1'b1;
      if (wrReg) begin
        case (stb.wrAddr[1:0])
          OFS_MODE:   modeA0 <= stb.wrData[0];
          OFS_SELECT: bufSel <= stb.wrData[SEL_W-1:0];
          OFS_SIZE: begin
            sizeReg <= stb.wrData[COUNT_W-1:0];
            rdPtr   <= '0;
            wrPtr   <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wrBuf) mem[{bufSel, wrPtr}] <= stb.wrData;
  end

  always_comb begin
    statusWord          = '0;
    statusWord[0]       = done;
    statusWord[8 +: COUNT_W] = remaining;
  end

  always_comb begin
    if (rdAddr[7]) rdData = mem[{bufSel, rdPtr}];
    else begin
      case (rdAddr[1:0])
        OFS_MODE:   rdData = DATA_W'(modeA0);
        OFS_SELECT: rdData = DATA_W'(bufSel);
        OFS_SIZE:   rdData = DATA_W'(sizeReg);
        default:    rdData = statusWord;
      endcase
    end
  end
endmodule

// File: rtl/sram_stream_port.sv
module sram_stream_port
  import sram_port_pkg::*;
#(
  parameter int NBUF    = 2,
  parameter int DEPTH   = 16,
  parameter int COUNT_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostCeN,
  input  logic        hostOeN,
  input  logic        hostWeN,
  input  logic [7:0]  hostAddr,
  inout  wire  [15:0] hostData
);
  portStrobe_t        stb;
  logic [COUNT_W-1:0] remaining;
  logic               done;
  logic               modeA0;
  logic [DATA_W-1:0]  rdData;
  logic               dqOe;

  sram_port_ctrl #(.COUNT_W(COUNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ceN(hostCeN), .oeN(hostOeN), .weN(hostWeN),
    .addr(hostAddr), .dataIn(hostData), .modeA0(modeA0),
    .stb(stb), .remaining(remaining), .done(done)
  );

  sram_port_datapath #(.NBUF(NBUF), .DEPTH(DEPTH), .COUNT_W(COUNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(hostAddr),
    .remaining(remaining), .done(done), .modeA0(modeA0), .rdData(rdData)
  );

  assign dqOe     = !hostCeN && !hostOeN && hostWeN;
  assign hostData = dqOe ? rdData : 'z;
endmodule

// File: rtl/sram_stream_port_chk.sv
module sram_stream_port_chk
  import sram_port_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input portStrobe_t        stb,
  input logic [COUNT_W-1:0] remaining,
  input logic               done
);
  logic sizeLoad;
  assign sizeLoad = stb.wrEn && !stb.wrAddr[7] && (stb.wrAddr[1:0] == OFS_SIZE);

  AST_DONE_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (remaining == '0)); // R7
  AST_NO_ADV_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !stb.advRd); // R7
  AST_SIZE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    sizeLoad |=> (remaining == $past(stb.wrData[COUNT_W-1:0])) && !done); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advRd && !sizeLoad) |=> (remaining == $past(remaining) - 1'b1)); // R3
  AST_SINGLE_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    stb.advRd |=> !stb.advRd); // R10
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.advRd && !sizeLoad) |=> $stable(remaining)); // R7
endmodule

bind sram_stream_port sram_stream_port_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .remaining(remaining), .done(done)
);

// File: tb/sram_stream_port_test.sv
module sram_stream_port_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostCeN = 1'b1, hostOeN = 1'b1, hostWeN = 1'b1;
  logic [7:0]  hostAddr = 8'h00;
  logic        drvEn = 1'b0;
  logic [15:0] drvData = 16'h0000;
  wire  [15:0] hostData;

  int errors = 0;
  int checks = 0;
  logic [15:0] model [2][16];

  assign hostData = drvEn ? drvData : 'z;
  for (genvar i = 0; i < 16; i++) begin : g_pull
    pullup (hostData[i]);
  end

  always #4 clk = ~clk;

  sram_stream_port uut (
    .clk(clk), .rstN(rstN), .hostCeN(hostCeN), .hostOeN(hostOeN),
    .hostWeN(hostWeN), .hostAddr(hostAddr), .hostData(hostData)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] statusOf(input int rem, input bit dn);
    return {rem[7:0], 7'b0, dn};
  endfunction

  task automatic hostWrite(input logic [7:0] a, input logic [15:0] d);
    hostAddr = a;
    repeat (4) @(negedge clk);
    drvData = d; drvEn = 1'b1; hostCeN = 1'b0;
    @(negedge clk);
    hostWeN = 1'b0;
    repeat (3) @(negedge clk);
    hostWeN = 1'b1;
    repeat (4) @(negedge clk);
    hostCeN = 1'b1; drvEn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // one read cycle ended by an output-enable rising edge
  task automatic hostRead(input logic [7:0] a, input int hold, output logic [15:0] d);
    hostAddr = a;
    repeat (4) @(negedge clk);
    hostCeN = 1'b0; hostOeN = 1'b0;
    repeat (hold) @(negedge clk);
    d = hostData;
    hostOeN = 1'b1;
    repeat (4) @(negedge clk);
    hostCeN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // output enable held low, address bit 0 toggled between words
  task automatic streamA0(input int sel, input int first, input int n, input string req);
    logic [15:0] d;
    hostAddr = 8'h80;
    repeat (4) @(negedge clk);
    hostCeN = 1'b0; hostOeN = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      d = hostData;
      chk(req, d, model[sel][first+k]);
      hostAddr[0] = ~hostAddr[0];
      repeat (4) @(negedge clk);
    end
    hostOeN = 1'b1;
    repeat (4) @(negedge clk);
    hostCeN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic fill(input int sel, input int n);
    for (int k = 0; k < n; k++) begin
      model[sel][k] = 16'($urandom) & 16'h7FFF;
      hostWrite(8'h80 | 8'(k), model[sel][k]);
    end
  endtask

  logic watchdogHit = 1'b0;
  initial begin
    repeat (190000) @(posedge clk);
    watchdogHit = 1'b1;
  end

  initial begin
    logic [15:0] d, d2;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R9 reset state
    hostRead(8'h00, 3, d); chk("R9 mode", d, 16'h0000);
    hostRead(8'h01, 3, d); chk("R9 select", d, 16'h0000);
    hostRead(8'h02, 3, d); chk("R9 size", d, 16'h0000);
    hostRead(8'h03, 3, d); chk("R9 status", d, 16'h0000);

    // R8 bus released when idle
    chk("R8 idle release", hostData, 16'hFFFF);

    // R1 R2 R3 R6: buffer 0, size 8, ten words, output-enable reads
    hostWrite(8'h02, 16'd8);
    hostRead(8'h03, 3, d); chk("R6 status after load", d, statusOf(8, 0));
    fill(0, 10);
    for (int k = 0; k < 8; k++) begin
      hostRead((k % 2) ? 8'hC5 : 8'h80, 3, d);
      chk("R3 R1 R2 oe-edge stream", d, model[0][k]);
    end
    hostRead(8'h03, 3, d); chk("R7 done status", d, statusOf(0, 1));
    hostRead(8'h80, 3, d);  chk("R7 no advance after done", d, model[0][8]);
    hostRead(8'h80, 3, d);  chk("R7 still held", d, model[0][8]);

    // R10 long low period advances once
    hostWrite(8'h02, 16'd3);
    hostRead(8'h80, 40, d); chk("R10 first word", d, model[0][0]);
    hostRead(8'h80, 3, d);  chk("R10 one step only", d, model[0][1]);
    hostRead(8'h03, 3, d);  chk("R10 count", d, statusOf(1, 0));

    // R4 address toggles ignored in output-enable mode
    hostAddr = 8'h80; repeat (4) @(negedge clk);
    hostCeN = 1'b0; hostOeN = 1'b0;
    for (int k = 0; k < 4; k++) begin
      hostAddr[0] = ~hostAddr[0]; repeat (4) @(negedge clk);
    end
    chk("R4 toggle ignored in mode 0", hostData, model[0][2]);
    hostAddr[0] = 1'b0; repeat (4) @(negedge clk);
    hostOeN = 1'b1; repeat (4) @(negedge clk); hostCeN = 1'b1;
    repeat (2) @(negedge clk);

    // R8 write enable low with output enable low: bus released
    hostAddr = 8'h03; repeat (4) @(negedge clk);
    hostCeN = 1'b0; hostOeN = 1'b0; hostWeN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 write enable low release", hostData, 16'hFFFF);
    hostWeN = 1'b1; hostOeN = 1'b1; repeat (4) @(negedge clk);
    hostCeN = 1'b1; repeat (2) @(negedge clk);

    // R5 R4: buffer 1 in toggle mode
    hostWrite(8'h01, 16'd1);
    hostWrite(8'h00, 16'd1);
    hostWrite(8'h02, 16'd4);
    fill(1, 5);
    streamA0(1, 0, 4, "R4 R5 toggle stream buffer 1");
    hostRead(8'h03, 3, d); chk("R7 done in toggle mode", d, statusOf(0, 1));
    // R4 output-enable pulses ignored in toggle mode
    hostWrite(8'h02, 16'd4);
    hostRead(8'h80, 3, d); hostRead(8'h80, 3, d2);
    chk("R4 oe ignored in mode 1", d2, model[1][0]);
    hostWrite(8'h01, 16'd0);
    hostWrite(8'h02, 16'd2);
    hostRead(8'h80, 3, d); chk("R5 buffer 0 kept", d, model[0][0]);

    // random rounds
    for (int r = 0; r < 8; r++) begin
      int sel, n, md;
      sel = int'($urandom % 2);
      n   = 1 + int'($urandom % 10);
      md  = int'($urandom % 2);
      hostWrite(8'h01, 16'(sel));
      hostWrite(8'h00, 16'(md));
      hostWrite(8'h02, 16'(n));
      fill(sel, n + 1);
      if (md == 1) streamA0(sel, 0, n, "R4 random toggle stream");
      else begin
        for (int k = 0; k < n; k++) begin
          hostRead(8'h80 | 8'($urandom % 128), 3, d);
          chk("R3 random oe stream", d, model[sel][k]);
        end
      end
      hostRead(8'h03, 3, d); chk("R7 random done", d, statusOf(0, 1));
      hostRead(8'h80, 3, d); chk("R7 random held", d, model[sel][n]);
    end

    if (watchdogHit) begin errors++; checks++; end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (watchdogHit);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule